// File: doc/BRIEF.md
# Interrupt context save sequencer

When an interrupt request is accepted, this block writes the processor context to the stack. The context is a 20-bit program counter and the flag bits that are saved. A stack-select input chooses the stack pointer: the user pointer or the interrupt pointer. The block copies that pointer, with the context, on the start pulse. It then issues a short series of writes on a byte-addressed memory port that accepts byte or 16-bit word writes.

The parity of the starting pointer S sets the write pattern. An even S gives two aligned word writes. An odd S gives four single-byte writes. In both cases the four bytes from S-4 to S-1 end up with the same contents. The top program-counter bits share one byte with the upper flag bits. When the last write is accepted, the block presents S-4 as the new stack pointer and pulses a done flag. A ready input can stall any write for as long as needed.

Top module: `ctx_push_seq`

## Requirements
- R1: A start pulse in idle with an even selected pointer S produces exactly two 16-bit writes (byte enable 2'b11): the word at S-2 first, then the word at S-4. The first write is presented in the cycle after the start pulse.
- R2: A start pulse in idle with an odd selected pointer S produces exactly four single-byte writes, at addresses S-1, S-2, S-3 and S-4 in that order.
- R3: Byte contents: S-4 holds pc[7:0], S-3 holds pc[15:8], S-2 holds the low flag byte, and S-1 holds {flag top nibble, pc[19:16]}.
- R4: Lane mapping: a word write at an even address carries the byte for that address in data[7:0] and the next byte in data[15:8]. A byte write at an even address uses data[7:0] with enable 2'b01. A byte write at an odd address uses data[15:8] with enable 2'b10. The unused lane is zero.
- R5: Stack select 0 picks the user pointer and 1 picks the interrupt pointer. The chosen select is reported with the new pointer.
- R6: When done is pulsed, the new stack pointer output equals S-4, modulo 2^ADDR_W.
- R7: Done is high for exactly one cycle, in the cycle after the final write is accepted.
- R8: While ready is low, the presented write (address, data, enables, strobe) holds unchanged. A write counts only on a cycle with strobe and ready both high.
- R9: A start pulse while a save is in progress is ignored. No extra writes occur and the running save is not changed.
- R10: The pointer, select and context are captured at the start pulse. Later changes on those inputs do not affect the running save.
- R11: A synchronous reset returns the block to idle with the write strobe and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Interrupt accepted, begin save |
| stk_sel_i | input | 1 | 0 = user pointer, 1 = interrupt pointer |
| usp_i | input | ADDR_W | User stack pointer |
| isp_i | input | ADDR_W | Interrupt stack pointer |
| pc_i | input | PC_W | Program counter to save |
| flg_lo_i | input | 8 | Low flag byte |
| flg_top_i | input | 8-(PC_W-16) | Upper flag bits saved beside the top PC bits |
| mem_rdy_i | input | 1 | Memory accepts the presented write |
| mem_addr_o | output | ADDR_W | Byte address of the write |
| mem_wdata_o | output | 16 | Write data, two byte lanes |
| mem_be_o | output | 2 | Byte enables, bit 0 = low lane |
| mem_we_o | output | 1 | Write strobe |
| sp_new_o | output | ADDR_W | Updated stack pointer (S-4) |
| sp_sel_o | output | 1 | Which pointer sp_new_o belongs to |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every pointer value of an 8-bit stack with both select values. This covers the wrap around zero, where S-1..S-4 cross address 0. A block that took parity from the wrong pointer, or used the wrong lane for an odd address, would write bytes to the wrong place or with the wrong enables.

Random ready stalls check that a held write never changes and that no stalled write is counted. Some runs fire a second start during a save and scramble the inputs, which catches a sequencer that restarts or reads live inputs. Done is checked on its exact cycle and on the cycle after, so a late, early or stretched pulse is caught.

// File: rtl/ctx_push_pkg.sv
package ctx_push_pkg;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned BUS_W    = 16;
  localparam int unsigned WORD_OPS = 2;
  localparam int unsigned BYTE_OPS = 4;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [1:0]        step_t;
endpackage

// File: rtl/ctx_push_lane.sv
module ctx_push_lane
  import ctx_push_pkg::*;
(
  input  logic             word_i,
  input  logic             lsb_i,
  input  lane_t            lo_i,
  input  lane_t            hi_i,
  output logic [BUS_W-1:0] data_o,
  output logic [1:0]       be_o
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam logic LANE_ID = 1'(g);
    logic hit;
    assign hit = (lsb_i == LANE_ID);
    assign be_o[g] = word_i | hit;
    if (g == 0) begin : g_low
      assign data_o[LANE_W-1:0] = (word_i | hit) ? lo_i : '0;
    end else begin : g_high
      assign data_o[BUS_W-1:LANE_W] = word_i ? hi_i : (hit ? lo_i : '0);
    end
  end
endmodule

// File: rtl/ctx_push_plan.sv
module ctx_push_plan
  import ctx_push_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PC_W   = 20
) (
  input  step_t                  step_i,
  input  logic                   aligned_i,
  input  logic [ADDR_W-1:0]      sp_i,
  input  logic [PC_W-1:0]        pc_i,
  input  lane_t                  flg_lo_i,
  input  logic [8-(PC_W-16)-1:0] flg_top_i,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [BUS_W-1:0]       data_o,
  output logic [1:0]             be_o
);
  localparam int unsigned PC_TOP_W = PC_W - 16;

  // slot k is the byte stored at S-1-k
  logic [3:0][LANE_W-1:0] slot;
  assign slot[0] = {flg_top_i, pc_i[PC_W-1 -: PC_TOP_W]};
  assign slot[1] = flg_lo_i;
  assign slot[2] = pc_i[15:8];
  assign slot[3] = pc_i[7:0];

  logic [ADDR_W-1:0] offs;
  lane_t             lo_b;
  lane_t             hi_b;

  always_comb begin
    if (aligned_i) begin
      offs = ADDR_W'(2) + ADDR_W'({step_i[0], 1'b0});
      lo_b = slot[{step_i[0], 1'b1}];
      hi_b = slot[{step_i[0], 1'b0}];
    end else begin
      offs = ADDR_W'(1) + ADDR_W'(step_i);
      lo_b = slot[step_i];
      hi_b = '0;
    end
  end

  assign addr_o = sp_i - offs;

  ctx_push_lane u_lane (
    .word_i (aligned_i),
    .lsb_i  (addr_o[0]),
    .lo_i   (lo_b),
    .hi_i   (hi_b),
    .data_o (data_o),
    .be_o   (be_o)
  );
endmodule

// File: rtl/ctx_push_ctrl.sv
module ctx_push_ctrl
  import ctx_push_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_i,
  input  logic  rdy_i,
  input  logic  aligned_i,
  output logic  busy_o,
  output logic  aligned_o,
  output step_t step_nxt_o,
  output logic  fire_o,
  output logic  load_o,
  output logic  fin_o,
  output logic  done_o
);
  step_t step_q;
  logic  busy_q;
  logic  aligned_q;
  logic  done_q;
  logic  accept;
  logic  last;

  assign fire_o     = start_i & ~busy_q;
  assign accept     = busy_q & rdy_i;
  assign last       = aligned_q ? (step_q == step_t'(WORD_OPS - 1))
                                : (step_q == step_t'(BYTE_OPS - 1));
  assign fin_o      = accept & last;
  assign load_o     = fire_o | (accept & ~last);
  assign step_nxt_o = fire_o ? '0 : step_q + step_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      step_q    <= '0;
      aligned_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (fire_o) begin
        busy_q    <= 1'b1;
        step_q    <= '0;
        aligned_q <= aligned_i;
      end else if (accept) begin
        if (last) busy_q <= 1'b0;
        else      step_q <= step_q + step_t'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign aligned_o = aligned_q;
  assign done_o    = done_q;

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy_q && start_i && !rdy_i |=> busy_q && $stable(step_q) && $stable(aligned_q));
  a_r1_word_count: assert property (@(posedge clk) disable iff (rst)
    busy_q && aligned_q |-> step_q < step_t'(WORD_OPS));
  a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy_q && !done_q);
endmodule

// File: rtl/ctx_push_seq.sv
module ctx_push_seq
  import ctx_push_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PC_W    = 20,
  parameter bit          USE_RDY = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   stk_sel_i,
  input  logic [ADDR_W-1:0]      usp_i,
  input  logic [ADDR_W-1:0]      isp_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic [7:0]             flg_lo_i,
  input  logic [8-(PC_W-16)-1:0] flg_top_i,
  input  logic                   mem_rdy_i,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [15:0]            mem_wdata_o,
  output logic [1:0]             mem_be_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      sp_new_o,
  output logic                   sp_sel_o,
  output logic                   done_o
);
  localparam int unsigned FLG_TOP_W = 8 - (PC_W - 16);
  localparam int unsigned FRAME_B   = 4;

  logic rdy_eff;
  if (USE_RDY) begin : g_rdy
    assign rdy_eff = mem_rdy_i;
  end else begin : g_no_rdy
    assign rdy_eff = 1'b1;
  end

  logic [ADDR_W-1:0]    sp_pick;
  logic [ADDR_W-1:0]    sp_q;
  logic [PC_W-1:0]      pc_q;
  lane_t                flo_q;
  logic [FLG_TOP_W-1:0] ftop_q;
  logic                 sel_q;

  logic  busy;
  logic  aligned_q;
  step_t step_nxt;
  logic  fire;
  logic  load;
  logic  fin;

  assign sp_pick = stk_sel_i ? isp_i : usp_i;

  ctx_push_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .rdy_i      (rdy_eff),
    .aligned_i  (~sp_pick[0]),
    .busy_o     (busy),
    .aligned_o  (aligned_q),
    .step_nxt_o (step_nxt),
    .fire_o     (fire),
    .load_o     (load),
    .fin_o      (fin),
    .done_o     (done_o)
  );

  // context seen by the planner: live inputs on the start cycle, captured copy after
  logic [ADDR_W-1:0]    sp_m;
  logic [PC_W-1:0]      pc_m;
  lane_t                flo_m;
  logic [FLG_TOP_W-1:0] ftop_m;
  logic                 aligned_m;

  assign sp_m      = fire ? sp_pick     : sp_q;
  assign pc_m      = fire ? pc_i        : pc_q;
  assign flo_m     = fire ? flg_lo_i    : flo_q;
  assign ftop_m    = fire ? flg_top_i   : ftop_q;
  assign aligned_m = fire ? ~sp_pick[0] : aligned_q;

  logic [ADDR_W-1:0] op_addr;
  logic [BUS_W-1:0]  op_data;
  logic [1:0]        op_be;

  ctx_push_plan #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_plan (
    .step_i    (step_nxt),
    .aligned_i (aligned_m),
    .sp_i      (sp_m),
    .pc_i      (pc_m),
    .flg_lo_i  (flo_m),
    .flg_top_i (ftop_m),
    .addr_o    (op_addr),
    .data_o    (op_data),
    .be_o      (op_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q        <= '0;
      pc_q        <= '0;
      flo_q       <= '0;
      ftop_q      <= '0;
      sel_q       <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_be_o    <= '0;
      sp_new_o    <= '0;
      sp_sel_o    <= 1'b0;
    end else begin
      if (fire) begin
        sp_q   <= sp_pick;
        pc_q   <= pc_i;
        flo_q  <= flg_lo_i;
        ftop_q <= flg_top_i;
        sel_q  <= stk_sel_i;
      end
      if (load) begin
        mem_addr_o  <= op_addr;
        mem_wdata_o <= op_data;
        mem_be_o    <= op_be;
      end
      if (fin) begin
        sp_new_o <= sp_q - ADDR_W'(FRAME_B);
        sp_sel_o <= sel_q;
      end
    end
  end

  assign mem_we_o = busy;

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    mem_we_o && !rdy_eff |=> mem_we_o && $stable(mem_addr_o)
                             && $stable(mem_wdata_o) && $stable(mem_be_o));
  a_r1_word_even: assert property (@(posedge clk) disable iff (rst)
    mem_we_o && mem_be_o == 2'b11 |-> !mem_addr_o[0]);
  a_r4_lane_parity: assert property (@(posedge clk) disable iff (rst)
    mem_we_o && mem_be_o != 2'b11 |-> mem_be_o == (mem_addr_o[0] ? 2'b10 : 2'b01));
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_be_o != 2'b00);
  a_r11_no_strobe: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_we_o && !done_o);
endmodule

// File: tb/test_ctx_push_seq.sv
module test_ctx_push_seq;
  localparam int CLK_P  = 10;
  localparam int AW     = 8;
  localparam int PCW    = 20;
  localparam int WD_LIM = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stk_sel_i = 1'b0, mem_rdy_i = 1'b1;
  logic [AW-1:0]  usp_i = '0, isp_i = '0;
  logic [PCW-1:0] pc_i = '0;
  logic [7:0]     flg_lo_i = '0;
  logic [3:0]     flg_top_i = '0;
  logic [AW-1:0]  mem_addr_o, sp_new_o;
  logic [15:0]    mem_wdata_o;
  logic [1:0]     mem_be_o;
  logic           mem_we_o, sp_sel_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_P/2) clk = ~clk;

  ctx_push_seq #(.ADDR_W(AW), .PC_W(PCW)) i_ctx_push_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .stk_sel_i(stk_sel_i),
    .usp_i(usp_i), .isp_i(isp_i), .pc_i(pc_i), .flg_lo_i(flg_lo_i),
    .flg_top_i(flg_top_i), .mem_rdy_i(mem_rdy_i), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_we_o(mem_we_o),
    .sp_new_o(sp_new_o), .sp_sel_o(sp_sel_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIM) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, WD_LIM);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected k-th write, computed from R1..R4
  task automatic exp_op(input int k, input logic [AW-1:0] s, input logic [PCW-1:0] pc,
                        input logic [7:0] flo, input logic [3:0] ftop,
                        output logic [AW-1:0] a, output logic [15:0] d, output logic [1:0] be);
    logic [7:0] b [4];
    b[0] = {ftop, pc[19:16]};
    b[1] = flo;
    b[2] = pc[15:8];
    b[3] = pc[7:0];
    if (!s[0]) begin
      a  = s - AW'(2 + 2*k);
      d  = {b[2*k], b[2*k+1]};
      be = 2'b11;
    end else begin
      a  = s - AW'(1 + k);
      d  = a[0] ? {b[k], 8'h00} : {8'h00, b[k]};
      be = a[0] ? 2'b10 : 2'b01;
    end
  endtask

  task automatic run(input logic sel, input logic [AW-1:0] up, input logic [AW-1:0] ip,
                     input logic [PCW-1:0] pc, input logic [7:0] flo, input logic [3:0] ftop,
                     input bit stall, input bit poke);
    logic [AW-1:0] s;
    int nops, k, cyc;
    bit have_prev;
    logic [AW-1:0] pa, ea;
    logic [15:0] pd, ed;
    logic [1:0] pb, eb;
    s = sel ? ip : up;
    nops = s[0] ? 4 : 2;
    @(negedge clk);
    start_i = 1'b1; stk_sel_i = sel; usp_i = up; isp_i = ip;
    pc_i = pc; flg_lo_i = flo; flg_top_i = ftop; mem_rdy_i = 1'b1;
    @(negedge clk);
    // R10: scramble inputs; R9: optional second start while busy
    start_i = poke; stk_sel_i = ~sel; usp_i = ~up; isp_i = ip + 8'd3;
    pc_i = ~pc; flg_lo_i = ~flo; flg_top_i = ~ftop;
    k = 0; cyc = 0; have_prev = 0;
    pa = '0; pd = '0; pb = '0;
    while (k < nops && cyc < 40) begin
      chk("R1/R2 strobe", 32'(mem_we_o), 32'd1);
      chk("R7 no early done", 32'(done_o), 32'd0);
      if (have_prev) begin
        chk("R8 hold addr", 32'(mem_addr_o), 32'(pa));
        chk("R8 hold data", 32'(mem_wdata_o), 32'(pd));
        chk("R8 hold be", 32'(mem_be_o), 32'(pb));
      end
      exp_op(k, s, pc, flo, ftop, ea, ed, eb);
      chk(s[0] ? "R2 addr" : "R1 addr", 32'(mem_addr_o), 32'(ea));
      chk("R3/R4 data", 32'(mem_wdata_o), 32'(ed));
      chk("R4 be", 32'(mem_be_o), 32'(eb));
      mem_rdy_i = stall ? (($urandom % 3) != 0) : 1'b1;
      if (mem_rdy_i) begin
        k++; have_prev = 0;
      end else begin
        have_prev = 1; pa = mem_addr_o; pd = mem_wdata_o; pb = mem_be_o;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    mem_rdy_i = 1'b1;
    chk("R2 op count", 32'(k), 32'(nops));
    chk("R7 done", 32'(done_o), 32'd1);
    chk("R7 strobe off", 32'(mem_we_o), 32'd0);
    chk("R6 new sp", 32'(sp_new_o), 32'(AW'(s - AW'(4))));
    chk("R5 select", 32'(sp_sel_o), 32'(sel));
    @(negedge clk);
    chk("R7 done width", 32'(done_o), 32'd0);
    chk("R9 no restart", 32'(mem_we_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset strobe", 32'(mem_we_o), 32'd0);
    chk("R11 reset done", 32'(done_o), 32'd0);

    for (int sp = 0; sp < 256; sp++) begin
      for (int sl = 0; sl < 2; sl++) begin
        logic [AW-1:0] v;
        v = AW'(sp);
        run(sl[0], sl[0] ? ~v : v, sl[0] ? v : (v ^ 8'h5A),
            {v[3:0], v, ~v}, v + 8'd17, v[7:4] ^ 4'h9, v[1], v[2]);
      end
    end

    // R11: reset in the middle of a save
    @(negedge clk);
    start_i = 1'b1; stk_sel_i = 1'b0; usp_i = 8'h41;
    @(negedge clk);
    start_i = 1'b0; mem_rdy_i = 1'b0;
    chk("R11 running", 32'(mem_we_o), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; mem_rdy_i = 1'b1;
    chk("R11 mid reset strobe", 32'(mem_we_o), 32'd0);
    chk("R11 mid reset done", 32'(done_o), 32'd0);
    @(negedge clk);
    chk("R11 stays idle", 32'(mem_we_o), 32'd0);
    run(1'b1, 8'h00, 8'h02, 20'hABCDE, 8'h5C, 4'h7, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule